// File: doc/BRIEF.md
# SPI Status and Event-Flag Register

This block is the status word of a queued SPI controller. The transfer engine reports events to it as single-cycle pulses: a frame has finished shifting, the finished frame was the last entry of its queue, an external master began a slave transfer, the receive side overflowed, and the FIFOs reached their fill or drain points. The block keeps a sticky flag for each of these events. Software clears a flag by writing 1 to its bit. The block also holds a running/stopped bit, which start and stop requests control and which the end of a queue clears automatically.

Reads of the status word also return the FIFO counters and pointers, which the FIFO logic supplies as inputs. A sticky flag raises the interrupt line when its enable bit is set. The fill and drain flags can be routed to two DMA request lines instead. A register-select mode makes every read return zero. A low-power disabled mode blocks all writes.

Top module: `spi_status_reg`

## Requirements
- R1: A write to address `STAT_ADDR` (default 0x2C) clears each flag whose bit in `wdata` is 1. Bits written as 0 leave their flags unchanged. Flag positions (LSB = bit 0): frame done 31, queue end 28, slave underrun 27, TX fill 25, RX overflow 19, RX drain 17.
- R2: When `ev_frame_end` pulses, the frame-done flag sets and stays set until it is cleared.
- R3: When `ev_frame_end` pulses with `frame_last` high, the queue-end flag sets. The flag is sticky.
- R4: Whenever the queue-end flag sets, the running bit (bit 30) goes to 0 on the same edge. This overrides a start request in the same cycle.
- R5: The underrun flag sets only when `slave_mode`, `ev_slave_start` and `tx_fifo_empty` are all high in the same cycle.
- R6: `start_req` sets the running bit and `stop_req` clears it. Stop wins when both arrive together. Writes do not change the running bit.
- R7: `ev_tx_fill`, `ev_rx_ovf` and `ev_rx_drain` each set their own sticky flag.
- R8: When a set event and a write-1 clear reach the same flag in the same cycle, the flag ends up set.
- R9: Bits [15:12], [11:8], [7:4] and [3:0] of a read hold `tx_cnt`, `tx_ptr`, `rx_cnt` and `rx_ptr`. Writes have no effect on them. Bits 29, 26, 24–20, 18 and 16 read 0.
- R10: `rdata` is registered one cycle after `addr` is presented. It is 0 when `zero_mode` is high or when the address differs from `STAT_ADDR`.
- R11: While `mdis_mode` is high, writes change no flag.
- R12: `irq` is the registered OR of every flag ANDed with its `int_en` bit (index order: done, queue end, underrun, TX fill, RX overflow, RX drain). When `dma_sel[0]` is set, the TX fill flag drives `dma_tx_req` and leaves the OR. When `dma_sel[1]` is set, the RX drain flag drives `dma_rx_req` and leaves the OR. These outputs follow the flag values of the same edge.
- R13: After reset, all flags, the running bit and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Register address for read and write |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data, write-1-to-clear flag bits |
| rdata | output | 32 | Registered read data |
| ev_frame_end | input | 1 | Frame finished shifting |
| frame_last | input | 1 | Finished frame was the queue's last entry |
| slave_mode | input | 1 | Controller operates as slave |
| ev_slave_start | input | 1 | External master began a transfer |
| tx_fifo_empty | input | 1 | TX FIFO holds no entry |
| ev_rx_ovf | input | 1 | RX FIFO overflowed |
| ev_tx_fill | input | 1 | TX FIFO can accept data |
| ev_rx_drain | input | 1 | RX FIFO holds data to drain |
| start_req | input | 1 | Enter running state |
| stop_req | input | 1 | Enter stopped state |
| zero_mode | input | 1 | Reads return zero |
| mdis_mode | input | 1 | Low-power disabled, writes blocked |
| tx_cnt | input | 4 | TX FIFO counter |
| tx_ptr | input | 4 | TX next pointer |
| rx_cnt | input | 4 | RX FIFO counter |
| rx_ptr | input | 4 | RX pop pointer |
| int_en | input | 6 | Per-flag interrupt enables |
| dma_sel | input | 2 | Route TX fill / RX drain to DMA |
| irq | output | 1 | Interrupt request |
| dma_tx_req | output | 1 | TX fill DMA request |
| dma_rx_req | output | 1 | RX drain DMA request |

## Verification
The hardest situations to reach are collisions on a single edge. A queue end can land together with a start request, and a hardware set can land together with a write-1 clear of the same flag. Uniform random stimulus rarely produces either collision while the flag is already in a known state. The bench therefore drives both collisions as directed cases. Its random phase also biases events and clears to fire often together, and a reference model scores every cycle through the read port and the request lines.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
  localparam int NFLAG   = 6;
  localparam int F_DONE  = 0;
  localparam int F_QEND  = 1;
  localparam int F_UNDR  = 2;
  localparam int F_TFILL = 3;
  localparam int F_ROVF  = 4;
  localparam int F_RDRN  = 5;
  localparam int RUN_BIT = 30;

  // bit position of each flag inside the status word
  function automatic int flag_pos(input int idx);
    case (idx)
      F_DONE:  flag_pos = 31;
      F_QEND:  flag_pos = 28;
      F_UNDR:  flag_pos = 27;
      F_TFILL: flag_pos = 25;
      F_ROVF:  flag_pos = 19;
      default: flag_pos = 17;
    endcase
  endfunction
endpackage

// File: rtl/spi_evt_decode.sv
module spi_evt_decode
  import spi_stat_pkg::*;
(
  input  logic             ev_frame_end,
  input  logic             frame_last,
  input  logic             slave_mode,
  input  logic             ev_slave_start,
  input  logic             tx_fifo_empty,
  input  logic             ev_rx_ovf,
  input  logic             ev_tx_fill,
  input  logic             ev_rx_drain,
  output logic [NFLAG-1:0] set_vec
);
  always_comb begin
    set_vec          = '0;
    set_vec[F_DONE]  = ev_frame_end;
    set_vec[F_QEND]  = ev_frame_end & frame_last;
    set_vec[F_UNDR]  = slave_mode & ev_slave_start & tx_fifo_empty;
    set_vec[F_TFILL] = ev_tx_fill;
    set_vec[F_ROVF]  = ev_rx_ovf;
    set_vec[F_RDRN]  = ev_rx_drain;
  end
endmodule

// File: rtl/spi_flag_bank.sv
module spi_flag_bank #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  input  logic         slave_mode,
  output logic [N-1:0] flags_d,
  output logic [N-1:0] flags_q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    assign flags_d[i] = set_vec[i] | (flags_q[i] & ~clr_vec[i]);

    always_ff @(posedge clk) begin
      if (rst) flags_q[i] <= 1'b0;
      else     flags_q[i] <= flags_d[i];
    end

    AST_CLR_NEEDS_W1: assert property (@(posedge clk) disable iff (rst)
      $fell(flags_q[i]) |-> $past(clr_vec[i])); // R1
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
      set_vec[i] |=> flags_q[i]); // R8
  end

  AST_UNDR_SLAVE_ONLY: assert property (@(posedge clk) disable iff (rst)
    $rose(flags_q[2]) |-> $past(slave_mode)); // R5
endmodule

// File: rtl/spi_run_ctrl.sv
module spi_run_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic qend_set,
  input  logic start_req,
  input  logic stop_req,
  output logic run_q
);
  logic run_d;

  always_comb begin
    run_d = run_q;
    if (qend_set || stop_req) run_d = 1'b0;
    else if (start_req)       run_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) run_q <= 1'b0;
    else     run_q <= run_d;
  end

  AST_START_RUNS: assert property (@(posedge clk) disable iff (rst)
    (start_req && !stop_req && !qend_set) |=> run_q); // R6
endmodule

// File: rtl/spi_status_reg.sv
module spi_status_reg
  import spi_stat_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 32,
  parameter int          CNT_W     = 4,
  parameter int          PTR_W     = 4,
  parameter logic [7:0]  STAT_ADDR = 8'h2C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              ev_frame_end,
  input  logic              frame_last,
  input  logic              slave_mode,
  input  logic              ev_slave_start,
  input  logic              tx_fifo_empty,
  input  logic              ev_rx_ovf,
  input  logic              ev_tx_fill,
  input  logic              ev_rx_drain,
  input  logic              start_req,
  input  logic              stop_req,
  input  logic              zero_mode,
  input  logic              mdis_mode,
  input  logic [CNT_W-1:0]  tx_cnt,
  input  logic [PTR_W-1:0]  tx_ptr,
  input  logic [CNT_W-1:0]  rx_cnt,
  input  logic [PTR_W-1:0]  rx_ptr,
  input  logic [NFLAG-1:0]  int_en,
  input  logic [1:0]        dma_sel,
  output logic              irq,
  output logic              dma_tx_req,
  output logic              dma_rx_req
);
  localparam int LOW_W = 2 * (CNT_W + PTR_W);
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(STAT_ADDR);

  logic [NFLAG-1:0] set_vec, clr_vec, flags_d, flags_q, irq_mask;
  logic             run_q, addr_hit, wr_ok;
  logic [DATA_W-1:0] stat_word;
  logic             unused_wdata;

  assign addr_hit     = (addr == HIT_ADDR);
  assign wr_ok        = wr_en & addr_hit & ~mdis_mode;
  assign unused_wdata = ^wdata;

  for (genvar i = 0; i < NFLAG; i++) begin : g_clr
    assign clr_vec[i] = wr_ok & wdata[flag_pos(i)];
  end

  spi_evt_decode u_dec (
    .ev_frame_end  (ev_frame_end),
    .frame_last    (frame_last),
    .slave_mode    (slave_mode),
    .ev_slave_start(ev_slave_start),
    .tx_fifo_empty (tx_fifo_empty),
    .ev_rx_ovf     (ev_rx_ovf),
    .ev_tx_fill    (ev_tx_fill),
    .ev_rx_drain   (ev_rx_drain),
    .set_vec       (set_vec)
  );

  spi_flag_bank #(.N(NFLAG)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .set_vec   (set_vec),
    .clr_vec   (clr_vec),
    .slave_mode(slave_mode),
    .flags_d   (flags_d),
    .flags_q   (flags_q)
  );

  spi_run_ctrl u_run (
    .clk      (clk),
    .rst      (rst),
    .qend_set (set_vec[F_QEND]),
    .start_req(start_req),
    .stop_req (stop_req),
    .run_q    (run_q)
  );

  always_comb begin
    stat_word = '0;
    stat_word[LOW_W-1:0] = {tx_cnt, tx_ptr, rx_cnt, rx_ptr};
    stat_word[RUN_BIT]   = run_q;
    for (int i = 0; i < NFLAG; i++) stat_word[flag_pos(i)] = flags_q[i];
  end

  always_comb begin
    irq_mask          = int_en;
    irq_mask[F_TFILL] = int_en[F_TFILL] & ~dma_sel[0];
    irq_mask[F_RDRN]  = int_en[F_RDRN] & ~dma_sel[1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata      <= '0;
      irq        <= 1'b0;
      dma_tx_req <= 1'b0;
      dma_rx_req <= 1'b0;
    end else begin
      rdata      <= (addr_hit && !zero_mode) ? stat_word : '0;
      irq        <= |(flags_d & irq_mask);
      dma_tx_req <= flags_d[F_TFILL] & dma_sel[0];
      dma_rx_req <= flags_d[F_RDRN] & dma_sel[1];
    end
  end

  AST_QEND_STOPS: assert property (@(posedge clk) disable iff (rst)
    $rose(flags_q[F_QEND]) |-> !run_q); // R4
  AST_ZERO_READ: assert property (@(posedge clk) disable iff (rst)
    $past(zero_mode) |-> (rdata == '0)); // R10
  AST_MDIS_NO_CLR: assert property (@(posedge clk) disable iff (rst)
    mdis_mode |-> (clr_vec == '0)); // R11
endmodule

// File: tb/sim_spi_status_reg.sv
module sim_spi_status_reg;
  logic clk = 0, rst = 1;
  always #4 clk = ~clk;

  logic [7:0]  addr = 0;
  logic        wr_en = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic ev_frame_end = 0, frame_last = 0, slave_mode = 0, ev_slave_start = 0;
  logic tx_fifo_empty = 0, ev_rx_ovf = 0, ev_tx_fill = 0, ev_rx_drain = 0;
  logic start_req = 0, stop_req = 0, zero_mode = 0, mdis_mode = 0;
  logic [3:0] tx_cnt = 0, tx_ptr = 0, rx_cnt = 0, rx_ptr = 0;
  logic [5:0] int_en = 0;
  logic [1:0] dma_sel = 0;
  logic irq, dma_tx_req, dma_rx_req;

  spi_status_reg u0 (.*);

  int errors = 0, checks = 0;
  bit done = 0;
  logic [5:0] mf = 0;
  logic       mr = 0;

  function automatic int pos(input int i);
    int p[6] = '{31, 28, 27, 25, 19, 17};
    return p[i];
  endfunction

  function automatic logic [31:0] pack(input logic [5:0] f, input logic r);
    logic [31:0] w = '0;
    for (int i = 0; i < 6; i++) w[pos(i)] = f[i];
    w[30] = r;
    w[15:0] = {tx_cnt, tx_ptr, rx_cnt, rx_ptr};
    return w;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: inputs already driven; predict, clock, compare
  task automatic step(input string req);
    logic [31:0] exp_rd;
    logic [5:0] setv, clrv, nf, msk;
    logic nr;
    exp_rd = (addr == 8'h2C && !zero_mode) ? pack(mf, mr) : 32'h0;
    setv = {ev_rx_drain, ev_rx_ovf, ev_tx_fill,
            slave_mode & ev_slave_start & tx_fifo_empty,
            ev_frame_end & frame_last, ev_frame_end};
    clrv = '0;
    if (wr_en && addr == 8'h2C && !mdis_mode)
      for (int i = 0; i < 6; i++) clrv[i] = wdata[pos(i)];
    nf = setv | (mf & ~clrv);
    nr = (setv[1] || stop_req) ? 1'b0 : (start_req ? 1'b1 : mr);
    msk = int_en;
    if (dma_sel[0]) msk[3] = 0;
    if (dma_sel[1]) msk[5] = 0;
    @(posedge clk); #1;
    chk({req, " rdata"}, rdata, exp_rd);
    chk({req, " irq R12"}, {31'b0, irq}, {31'b0, |(nf & msk)});
    chk({req, " dma R12"}, {30'b0, dma_tx_req, dma_rx_req},
        {30'b0, nf[3] & dma_sel[0], nf[5] & dma_sel[1]});
    mf = nf; mr = nr;
    @(negedge clk);
  endtask

  task automatic idle();
    {ev_frame_end, frame_last, slave_mode, ev_slave_start, tx_fifo_empty} = 0;
    {ev_rx_ovf, ev_tx_fill, ev_rx_drain, start_req, stop_req} = 0;
    {zero_mode, mdis_mode, wr_en} = 0;
    wdata = 0; addr = 8'h2C;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    idle();
    step("R13 reset");
    chk("R13 outputs after reset", {29'b0, irq, dma_tx_req, dma_rx_req}, 0);

    // R2/R3: frame end with last marker, also start in same cycle (R4)
    start_req = 1; step("R6 start");
    idle(); step("R6 running read");
    ev_frame_end = 1; frame_last = 1; start_req = 1; step("R4 qend beats start");
    idle(); step("R3 R4 readback");
    // R1: write 0 changes nothing; write 1 clears
    wr_en = 1; wdata = 0; step("R1 write zero");
    idle(); wr_en = 1; wdata = 32'h8000_0000; step("R1 clear done");
    idle(); step("R1 readback");
    // R8: set and clear together
    ev_frame_end = 1; wr_en = 1; wdata = 32'hFFFF_FFFF; step("R8 set wins");
    idle(); step("R8 readback");
    // R11: write blocked in mdis
    mdis_mode = 1; wr_en = 1; wdata = 32'hFFFF_FFFF; step("R11 mdis write");
    idle(); step("R11 readback");
    // R5: underrun needs slave mode
    ev_slave_start = 1; tx_fifo_empty = 1; step("R5 master mode");
    idle(); slave_mode = 1; ev_slave_start = 1; tx_fifo_empty = 1; step("R5 slave");
    idle(); step("R5 readback");
    // R9/R10: counters, zero mode, other address
    tx_cnt = 4'hA; tx_ptr = 4'h5; rx_cnt = 4'h3; rx_ptr = 4'hC;
    wr_en = 1; wdata = 32'h0000_FFFF; step("R9 counters");
    idle(); zero_mode = 1; step("R10 zero mode");
    idle(); addr = 8'h28; step("R10 other address");
    // R7/R12
    idle(); ev_tx_fill = 1; ev_rx_drain = 1; ev_rx_ovf = 1; int_en = 6'h3F;
    dma_sel = 2'b11; step("R7 R12 fill drain");
    idle(); start_req = 1; stop_req = 1; step("R6 stop wins");

    for (int n = 0; n < 3000; n++) begin
      idle();
      ev_frame_end   = ($urandom % 4) == 0;
      frame_last     = $urandom % 2;
      slave_mode     = $urandom % 2;
      ev_slave_start = $urandom % 2;
      tx_fifo_empty  = $urandom % 2;
      ev_rx_ovf      = ($urandom % 5) == 0;
      ev_tx_fill     = ($urandom % 4) == 0;
      ev_rx_drain    = ($urandom % 4) == 0;
      start_req      = ($urandom % 3) == 0;
      stop_req       = ($urandom % 6) == 0;
      zero_mode      = ($urandom % 10) == 0;
      mdis_mode      = ($urandom % 8) == 0;
      wr_en          = ($urandom % 3) == 0;
      wdata          = $urandom;
      addr           = (($urandom % 8) == 0) ? 8'($urandom) : 8'h2C;
      int_en         = 6'($urandom);
      dma_sel        = 2'($urandom);
      {tx_cnt, tx_ptr, rx_cnt, rx_ptr} = 16'($urandom);
      step("R1 R7 R8 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule